// File: doc/BRIEF.md
# Ring-Oscillator Frequency-Race Response Generator

This block turns a challenge into a response bit by racing two oscillators chosen from an array. The challenge names oscillator A and oscillator B. The block drives enable lines that gate only those two rings, for a fixed number of system clocks. Each selected ring output is brought into the clock domain through a synchroniser, and its rising edges are counted in a saturating counter. When the window closes, a short drain period lets edges still in the synchroniser reach the counters. The two counts are then compared. The response is 1 only when A counted strictly more edges than B.

A multi-bit mode repeats the race K times. Each run uses the next pair of oscillators, with both indices moved up by one and wrapping. Each bit is shifted into a response word, and the first bit ends up in the least significant position. A caller starts an operation with a one-cycle `start` while the block is idle. `busy` is then high until the operation ends, and a single `done` pulse marks the point where the outputs are valid.

Top module: `ro_puf_resp`

## Requirements
- R1: After reset `busy`, `done`, `resp_bit`, `resp_word` and `osc_en` are all 0.
- R2: During a comparison, `osc_en` has bit A and bit B set and no other bit, for exactly WINDOW consecutive clock cycles. At all other times `osc_en` is 0. When A equals B, a single bit is set.
- R3: `resp_bit` is 1 when the rising-edge count of oscillator A is strictly greater than that of oscillator B. Otherwise it is 0. Equal counts, including the case where A and B are the same oscillator, give 0.
- R4: Each edge counter saturates at all ones and never wraps inside a window. An oscillator whose edges exceed the counter range still wins against any slower one.
- R5: `busy` is 1 in the cycle after `start` is accepted. `done` is high for exactly one cycle, in which `busy` is already 0. `resp_bit` and `resp_word` are valid while `done` is high.
- R6: `start` is ignored while `busy` is high. A second `start` during an operation does not change the selected pair or the result, and it produces no extra `done`.
- R7: With `multi` = 1 at start, K comparisons run back to back. Comparison i uses oscillators (A+i) mod N_OSC and (B+i) mod N_OSC, and its result lands in `resp_word[i]`. `resp_word` is cleared when the run starts, `done` pulses once after the last comparison, and `resp_bit` then holds the last result.
- R8: With `multi` = 0 at start, a single comparison runs and `resp_word` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; taken only when idle |
| multi | input | 1 | 1 = K-bit run, 0 = single comparison |
| chal_a | input | $clog2(N_OSC) | Index of oscillator A (first pair in a multi run) |
| chal_b | input | $clog2(N_OSC) | Index of oscillator B (first pair in a multi run) |
| osc_in | input | N_OSC | Free-running oscillator outputs; each level lasts at least two clocks |
| osc_en | output | N_OSC | Gate enables for the oscillator array |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| resp_bit | output | 1 | Result of the most recent comparison |
| resp_word | output | K | Multi-bit response, first result in bit 0 |

## Verification
The oscillator model gives each ring its own half-period, and a gated ring sits at 0 while its enable is low. This way a pair's outcome follows from which half-period is shorter. Swapped pairs check that the comparison is ordered and not symmetric. Pairs with equal half-periods, and a pair where A equals B, produce identical edge streams, so they expose a greater-or-equal rule in place of the strict one. A ring fast enough to overrun a deliberately narrow counter tells saturation apart from wrap-around. Multi-bit runs from several base pairs, including one that wraps past the top index, show the pair stepping, the bit order in the word, and the single `done`. A stray `start` in the middle of a window shows that the enables are held and that no second result appears.

// File: rtl/puf_pkg.sv
package puf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DRAIN = 2'd2
   } puf_state_e;

   function automatic int unsigned max_u(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

endpackage

// File: rtl/puf_edge_sync.sv
module puf_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("puf_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] shreg;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         prev  <= 1'b0;
      end else begin
         shreg <= {shreg[STAGES-2:0], osc};
         prev  <= shreg[STAGES-1];
      end
   end

   assign rise = shreg[STAGES-1] & ~prev;
endmodule

// File: rtl/puf_sat_cnt.sv
module puf_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   if (W < 2) begin : g_bad_w
      $error("puf_sat_cnt: W must be at least 2");
   end

   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (en && inc && (cnt != TOP))
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/puf_seq.sv
module puf_seq
   import puf_pkg::*;
#(
   parameter int WINDOW    = 1024,
   parameter int DRAIN_CYC = 3,
   parameter int K         = 8,
   parameter int SEL_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             multi,
   input  logic [SEL_W-1:0] chal_a,
   input  logic [SEL_W-1:0] chal_b,
   output logic             busy,
   output logic             run,
   output logic             cnt_clr,
   output logic             cnt_en,
   output logic             decide,
   output logic             last,
   output logic             multi_q,
   output logic             start_acc,
   output logic [SEL_W-1:0] sel_a,
   output logic [SEL_W-1:0] sel_b
);
   localparam int TW = $clog2(max_u(WINDOW, DRAIN_CYC) + 1);
   localparam int KW = (K > 1) ? $clog2(K) : 1;
   localparam logic [TW-1:0] WIN_LAST   = TW'(WINDOW - 1);
   localparam logic [TW-1:0] DRAIN_LAST = TW'(DRAIN_CYC - 1);
   localparam logic [KW-1:0] IDX_LAST   = KW'(K - 1);

   puf_state_e       state;
   logic [TW-1:0]    tmr;
   logic [KW-1:0]    idx;
   logic [SEL_W-1:0] base_a, base_b;
   logic             more;

   assign start_acc = (state == ST_IDLE) && start;
   assign more      = multi_q && (idx != IDX_LAST);
   assign decide    = (state == ST_DRAIN) && (tmr == DRAIN_LAST);
   assign last      = decide && !more;
   assign busy      = (state != ST_IDLE);
   assign run       = (state == ST_RUN);
   assign cnt_en    = (state == ST_RUN) || (state == ST_DRAIN);
   assign cnt_clr   = start_acc || decide;
   assign sel_a     = base_a + SEL_W'(idx);
   assign sel_b     = base_b + SEL_W'(idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         tmr     <= '0;
         idx     <= '0;
         base_a  <= '0;
         base_b  <= '0;
         multi_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_RUN;
                  tmr     <= '0;
                  idx     <= '0;
                  base_a  <= chal_a;
                  base_b  <= chal_b;
                  multi_q <= multi;
               end
            end
            ST_RUN: begin
               if (tmr == WIN_LAST) begin
                  state <= ST_DRAIN;
                  tmr   <= '0;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (tmr == DRAIN_LAST) begin
                  tmr <= '0;
                  if (more) begin
                     idx   <= idx + 1'b1;
                     state <= ST_RUN;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ro_puf_resp.sv
module ro_puf_resp #(
   parameter int N_OSC       = 16,
   parameter int WINDOW      = 1024,
   parameter int CNT_W       = 16,
   parameter int K           = 8,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(N_OSC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             multi,
   input  logic [SEL_W-1:0] chal_a,
   input  logic [SEL_W-1:0] chal_b,
   input  logic [N_OSC-1:0] osc_in,
   output logic [N_OSC-1:0] osc_en,
   output logic             busy,
   output logic             done,
   output logic             resp_bit,
   output logic [K-1:0]     resp_word
);
   localparam int DRAIN_CYC = SYNC_STAGES + 1;

   if (N_OSC < 2 || (N_OSC & (N_OSC - 1)) != 0) begin : g_bad_n
      $error("ro_puf_resp: N_OSC must be a power of two, at least 2");
   end
   if (K < 2) begin : g_bad_k
      $error("ro_puf_resp: K must be at least 2");
   end
   if (WINDOW < 2) begin : g_bad_win
      $error("ro_puf_resp: WINDOW must be at least 2");
   end

   logic             run, cnt_clr, cnt_en, decide, last, multi_q, start_acc;
   logic [SEL_W-1:0] sel_a, sel_b;
   logic [1:0]       osc_pick, rise;
   logic [CNT_W-1:0] cnt_a, cnt_b;
   logic             a_wins;

   puf_seq #(
      .WINDOW    (WINDOW),
      .DRAIN_CYC (DRAIN_CYC),
      .K         (K),
      .SEL_W     (SEL_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .multi     (multi),
      .chal_a    (chal_a),
      .chal_b    (chal_b),
      .busy      (busy),
      .run       (run),
      .cnt_clr   (cnt_clr),
      .cnt_en    (cnt_en),
      .decide    (decide),
      .last      (last),
      .multi_q   (multi_q),
      .start_acc (start_acc),
      .sel_a     (sel_a),
      .sel_b     (sel_b)
   );

   for (genvar g = 0; g < N_OSC; g++) begin : g_gate
      assign osc_en[g] = run && ((sel_a == SEL_W'(g)) || (sel_b == SEL_W'(g)));
   end

   assign osc_pick[0] = osc_in[sel_a];
   assign osc_pick[1] = osc_in[sel_b];

   for (genvar c = 0; c < 2; c++) begin : g_chan
      puf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .osc   (osc_pick[c]),
         .rise  (rise[c])
      );
   end

   puf_sat_cnt #(.W(CNT_W)) u_cnt_a (
      .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .en (cnt_en),
      .inc (rise[0]), .cnt (cnt_a)
   );
   puf_sat_cnt #(.W(CNT_W)) u_cnt_b (
      .clk (clk), .rst_n (rst_n), .clr (cnt_clr), .en (cnt_en),
      .inc (rise[1]), .cnt (cnt_b)
   );

   assign a_wins = (cnt_a > cnt_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_bit  <= 1'b0;
         resp_word <= '0;
         done      <= 1'b0;
      end else begin
         done <= last;
         if (start_acc && multi)
            resp_word <= '0;
         else if (decide && multi_q)
            resp_word <= {a_wins, resp_word[K-1:1]};
         if (decide)
            resp_bit <= a_wins;
      end
   end
endmodule

// File: rtl/puf_chk.sv
module puf_chk #(
   parameter int N_OSC = 16,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             done,
   input logic             cnt_clr,
   input logic [N_OSC-1:0] osc_en,
   input logic [CNT_W-1:0] cnt_a,
   input logic [CNT_W-1:0] cnt_b
);
   // R2: enables only while an operation runs
   assert_en_only_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_en != '0) |-> busy);

   // R2: never more than the two selected rings
   assert_two_rings_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(osc_en) <= 2);

   // R6: the gated pair holds steady through a window, a stray start included
   assert_pair_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((osc_en != '0) && ($past(osc_en) != '0)) |-> $stable(osc_en));

   // R4: counters only climb between clears
   assert_no_wrap_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (cnt_a >= $past(cnt_a)));
   assert_no_wrap_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_clr |=> (cnt_b >= $past(cnt_b)));

   // R5: done is a single-cycle pulse seen with busy low
   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind ro_puf_resp puf_chk #(.N_OSC(N_OSC), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .cnt_clr (cnt_clr),
   .osc_en  (osc_en),
   .cnt_a   (cnt_a),
   .cnt_b   (cnt_b)
);

// File: tb/sim_ro_puf_resp.sv
`timescale 1ns/1ps
module sim_ro_puf_resp;
   localparam int N   = 8;
   localparam int WIN = 80;
   localparam int CW  = 4;
   localparam int KB  = 3;
   localparam int SW  = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          multi = 1'b0;
   logic [SW-1:0] chal_a = '0, chal_b = '0;
   logic [N-1:0]  osc_in = '0;
   logic [N-1:0]  osc_en;
   logic          busy, done, resp_bit;
   logic [KB-1:0] resp_word;

   int nchk = 0, nfail = 0, cyc = 0;
   int hp [N] = '{2, 3, 4, 5, 7, 4, 3, 6};
   int ph [N];
   int exp_bit_q[$];
   int exp_word_q[$];
   int run_len = 0;
   int word_now = 0;

   always #2 clk = ~clk;

   ro_puf_resp #(.N_OSC(N), .WINDOW(WIN), .CNT_W(CNT_W_P()), .K(KB), .SYNC_STAGES(2)) u0 (
      .clk (clk), .rst_n (rst_n), .start (start), .multi (multi),
      .chal_a (chal_a), .chal_b (chal_b), .osc_in (osc_in), .osc_en (osc_en),
      .busy (busy), .done (done), .resp_bit (resp_bit), .resp_word (resp_word)
   );

   function automatic int CNT_W_P();
      return CW;
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // gated ring model: held at 0 while its enable is low
   always @(negedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (!osc_en[i]) begin
            osc_in[i] = 1'b0;
            ph[i] = 0;
         end else begin
            ph[i]++;
            if (ph[i] == hp[i]) begin
               osc_in[i] = ~osc_in[i];
               ph[i] = 0;
            end
         end
      end
   end

   // R2: enable window length
   always @(negedge clk) begin
      if (osc_en != '0) run_len++;
      else if (run_len != 0) begin
         check(run_len == WIN, "R2 window length", run_len, WIN);
         run_len = 0;
      end
   end

   // monitor: scoreboard compare on done
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_bit_q.size() == 0) begin
            check(1'b0, "R6 unexpected done", 1, 0);
         end else begin
            int eb, ew;
            eb = exp_bit_q.pop_front();
            ew = exp_word_q.pop_front();
            check(resp_bit == eb[0], "R3 resp_bit", int'(resp_bit), eb);
            check(int'(resp_word) == ew, "R7/R8 resp_word", int'(resp_word), ew);
            check(!busy, "R5 busy low with done", int'(busy), 0);
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         nfail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   function automatic int win(input int a, input int b);
      return (hp[a % N] < hp[b % N]) ? 1 : 0;
   endfunction

   task automatic run(input int a, input int b, input bit m, input bit spur);
      int eb, ew;
      if (m) begin
         ew = 0;
         for (int i = 0; i < KB; i++) begin
            eb = win(a + i, b + i);
            ew |= eb << i;
         end
         word_now = ew;
      end else begin
         eb = win(a, b);
         ew = word_now;
      end
      exp_bit_q.push_back(eb);
      exp_word_q.push_back(ew);
      @(negedge clk);
      chal_a = SW'(a); chal_b = SW'(b); multi = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R5 busy after start", int'(busy), 1);
      repeat (4) @(negedge clk);
      check(osc_en == ((N'(1) << a) | (N'(1) << b)), "R2 enable mask",
            int'(osc_en), int'((N'(1) << a) | (N'(1) << b)));
      if (spur) begin
         chal_a = SW'(b); chal_b = SW'(a); multi = ~m; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         check(osc_en == ((N'(1) << a) | (N'(1) << b)), "R6 mask after stray start",
               int'(osc_en), int'((N'(1) << a) | (N'(1) << b)));
      end
      while (exp_bit_q.size() != 0) @(negedge clk);
      repeat (6) @(negedge clk);
      check(!busy, "R6 idle after operation", int'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!busy && !done && !resp_bit && resp_word == '0 && osc_en == '0,
            "R1 reset state", int'({busy, done, resp_bit, resp_word, osc_en}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(osc_en == '0 && !busy, "R1 idle after reset", int'(osc_en), 0);

      run(0, 1, 1'b0, 1'b0);   // R4: ring 0 overruns the counter, still wins
      run(1, 0, 1'b0, 1'b0);   // R3 swapped
      run(2, 3, 1'b0, 1'b0);   // R3
      run(4, 7, 1'b0, 1'b0);   // R3 slower A
      run(7, 4, 1'b0, 1'b0);   // R3
      run(1, 6, 1'b0, 1'b0);   // R3 tie
      run(6, 1, 1'b0, 1'b0);   // R3 tie swapped
      run(3, 3, 1'b0, 1'b0);   // R3 same ring
      run(4, 2, 1'b0, 1'b1);   // R6 stray start
      run(0, 3, 1'b1, 1'b0);   // R7 word 3'b011
      run(6, 0, 1'b1, 1'b0);   // R7 word 3'b100
      run(5, 7, 1'b1, 1'b0);   // R7 wrap, word 3'b001
      run(2, 3, 1'b0, 1'b0);   // R8 word kept
      check(int'(resp_word) == word_now, "R8 word unchanged", int'(resp_word), word_now);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule